// File: doc/BRIEF.md
# Overlapping Zero-One-Zero Serial Detector

This block watches a serial bit stream arriving one bit per rising clock edge. It raises a flag whenever the three most recent bits it has taken in, oldest first, were zero, one, zero. Matches may overlap: the closing zero of one match can also open the next one. A stream such as 0,1,0,1,0 therefore produces two flags.

The detector is a four-state Moore machine held in two D flip-flops. The flag is decoded from the registered state alone, so it is glitch-free. It appears in the cycle that follows the clock edge which captured the closing zero. Next-state and flag logic are minimal sum-of-products terms. A synchronous, active-high reset returns the machine to its idle state.

Top module: `seq_zoz_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the state returns to idle (nothing of the pattern seen) and `hit` is 0, both during reset and in the first cycle after it.
- R2: `hit` is 1 in the cycle after an edge exactly when the last three bits captured since reset, oldest first, are 0,1,0. Otherwise it is 0.
- R3: Overlaps are detected. After reset, the stream 0,1,0,1,0,1,0 gives `hit` high after the 3rd, 5th and 7th bits and low after all the others.
- R4: After reset, the stream 0,0,0,1,0,1,0,0,1,0,1,1 gives the per-cycle `hit` sequence 0,0,0,0,1,0,1,0,0,1,0,0.
- R5: `hit` depends only on the state. Changing `bit_in` between clock edges never changes `hit`, and `hit` is never high in two consecutive cycles.
- R6: A long run of zeros keeps the machine in its leading-zero state with `hit` low. A long run of ones returns it to idle with `hit` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one stream bit per edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| bit_in | input | 1 | Serial stream bit sampled at each rising edge |
| hit | output | 1 | High for one cycle after a 0,1,0 match completes |

## Verification
Every result of this block is due exactly one edge after the bit that causes it. The bench drives each bit at a falling edge. It updates its three-bit history model just after the rising edge that captures the bit, then compares `hit` at the next falling edge. Between those two points `bit_in` is deliberately flipped, and `hit` must hold its value through the flip. Reset is checked the same way, one edge after it is applied and again one edge after it is released.

// File: rtl/seq_zoz_detector.sv
module seq_zoz_detector (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit
);
  localparam logic [1:0] IDLE = 2'b00;

  logic [1:0] state_q;
  logic       nxt_hi, nxt_lo;

  assign nxt_lo = ~bit_in;
  assign nxt_hi = (bit_in & state_q[0]) | (~bit_in & state_q[1] & ~state_q[0]);

  always_ff @(posedge clk) begin
    if (rst) state_q <= IDLE;
    else     state_q <= {nxt_hi, nxt_lo};
  end

  assign hit = state_q[1] & state_q[0];
endmodule

// File: rtl/seq_zoz_detector_chk.sv
module seq_zoz_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_in,
  input logic       hit,
  input logic [1:0] state
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state == 2'b00 && !hit));

  assert_match_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b10 && !bit_in) |=> hit);

  assert_overlap_reseed_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && bit_in) |=> (state == 2'b10));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  assert_zero_run_R6: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b01 && !bit_in) |=> (state == 2'b01 && !hit));

  assert_one_run_R6: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b00 && bit_in) |=> (state == 2'b00));
endmodule

bind seq_zoz_detector seq_zoz_detector_chk u_chk (
  .clk(clk), .rst(rst), .bit_in(bit_in), .hit(hit), .state(state_q)
);

// File: tb/tb_seq_zoz_detector.sv
module tb_seq_zoz_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit;

  int checks = 0;
  int errors = 0;
  logic [2:0] hist = 3'b000;
  int seen = 0;
  logic exp_hit = 1'b0;

  seq_zoz_detector dut (.clk(clk), .rst(rst), .bit_in(bit_in), .hit(hit));

  always #5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_in = 1'b0;
    @(posedge clk);
    #1;
    hist = 3'b000;
    seen = 0;
    @(negedge clk);
    check(hit, 1'b0, "R1");
    rst = 1'b0;
  endtask

  task automatic push(input logic b, input string req, input logic use_given, input logic given);
    logic held;
    bit_in = b;
    @(posedge clk);
    #1;
    hist = {hist[1:0], b};
    seen++;
    exp_hit = (seen >= 3) && (hist == 3'b010);
    if (use_given) exp_hit = given;
    #1;
    held = hit;
    bit_in = ~b;
    @(negedge clk);
    check(hit, exp_hit, req);
    check(hit, held, "R5");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] ex_in;
    logic [11:0] ex_out;
    logic [6:0]  ov_in;
    logic [6:0]  ov_out;
    ex_in  = 12'b000101001011;
    ex_out = 12'b000010100100;
    ov_in  = 7'b0101010;
    ov_out = 7'b0010101;

    do_reset();
    push(1'b1, "R1", 1'b1, 1'b0);

    do_reset();
    for (int i = 11; i >= 0; i--) push(ex_in[i], "R4", 1'b1, ex_out[i]);

    do_reset();
    for (int i = 6; i >= 0; i--) push(ov_in[i], "R3", 1'b1, ov_out[i]);

    do_reset();
    for (int i = 0; i < 40; i++) push(1'b0, "R6", 1'b1, 1'b0);
    for (int i = 0; i < 40; i++) push(1'b1, "R6", 1'b1, 1'b0);
    push(1'b0, "R6", 1'b1, 1'b0);
    push(1'b1, "R6", 1'b1, 1'b0);
    push(1'b0, "R2", 1'b1, 1'b1);

    for (int v = 0; v < 256; v++) begin
      do_reset();
      for (int k = 7; k >= 0; k--) push(v[k], "R2", 1'b0, 1'b0);
    end

    for (int i = 0; i < 600; i++) push(((i * 7 + i / 5) % 3) == 1, "R2", 1'b0, 1'b0);
    do_reset();
    push(1'b0, "R1", 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule